// File: doc/BRIEF.md
# Windowed Persistence Interrupt Generator

This block watches the stream of channel 0 conversion results from a light sensor front end. Each time a result strobe arrives it decides whether the sample lies outside a programmable window: at or below a low bound, or strictly above a high bound. It keeps a count of consecutive out-of-window samples and raises a latched, active-low interrupt once that run reaches a programmed persistence. A persistence of zero turns the block into a per-conversion tick that fires on every result whatever the bounds are.

The host programs the two 16-bit bounds, the 4-bit persistence and a 2-bit mode field. It releases the interrupt with a single-cycle clear strobe. The bounds, persistence and mode arrive as plain levels from a register bank held elsewhere. The block only adds the comparison, the run count and the latch.

Top module: `lux_persist_irq`

## Requirements
- R1: A sample counts as out of window when `sample <= bound_lo` (inclusive) or `sample > bound_hi` (strict). A sample equal to `bound_hi`, or strictly between the bounds, is in window.
- R2: With `persist_sel` = 0 and the mode enabled, every result strobe sets the interrupt, in window or not.
- R3: With `persist_sel` = N (1 to 15), the interrupt is set on the result that completes N consecutive out-of-window samples and not on an earlier one. Clock cycles without a result strobe leave the run count unchanged.
- R4: An in-window result sets the run count back to zero.
- R5: The run count saturates at 15 and does not wrap, so a run longer than 15 still satisfies a persistence of 15.
- R6: Once set, `irq_n` stays low until a cycle with `irq_clear` high. That cycle releases the pin on the following clock and zeroes the run count, so a fresh run of N is needed to fire again.
- R7: When `irq_clear` and a result that qualifies (counted from a zeroed run) arrive in the same clock, the interrupt ends set.
- R8: `irq_mode` = 2'b01 enables the interrupt. Any other value holds `irq_n` high and prevents new setting, while the run count keeps tracking samples. An interrupt set earlier reappears when the mode returns to 2'b01.
- R9: After reset `irq_n` is high and the run count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid | input | 1 | One-cycle strobe: a new channel 0 result is on `sample` |
| sample | input | 16 | Channel 0 conversion result |
| bound_lo | input | 16 | Low bound (inclusive) |
| bound_hi | input | 16 | High bound (strict) |
| persist_sel | input | 4 | Persistence: 0 = every result, N = N consecutive out-of-window results |
| irq_mode | input | 2 | 2'b01 enables the interrupt, other values disable it |
| irq_clear | input | 1 | One-cycle strobe that releases the interrupt and zeroes the run |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Samples are placed exactly on each bound and one step to either side, which separates inclusive from strict comparison. Runs of out-of-window samples are stopped one short of the persistence, broken by a single in-window sample, or padded with idle cycles. These runs show whether the count fires early, fails to restart, or advances on cycles without a strobe. A run of sixteen samples with the mode disabled, followed by one enabled sample at persistence 15, distinguishes a saturating count from a wrapping one and confirms that tracking continues while disabled. Clears are issued alone and together with qualifying and non-qualifying samples to pin down which action wins in a collision.

// File: rtl/lux_irq_pkg.sv
// Package: shared types and constants for the windowed persistence interrupt.
// Assumes the mode field encoding in which 2'b01 alone enables the pin.
package lux_irq_pkg;

    // Result of comparing one sample against the two bounds
    typedef struct packed {
        logic below;   // sample at or under the low bound
        logic above;   // sample strictly over the high bound
    } window_flags_t;

    localparam logic [1:0] IRQ_MODE_LEVEL = 2'b01;

    function automatic logic flags_outside(input window_flags_t f);
        return f.below | f.above;
    endfunction

endpackage

// File: rtl/window_cmp.sv
// Module: window_cmp
// Compares one sample against a low bound (inclusive) and a high bound (strict).
// Purely combinational. Assumes the bounds are unsigned and need not be ordered.
module window_cmp
    import lux_irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] bound_lo,
    input  logic [DATA_W-1:0] bound_hi,
    output window_flags_t     flags
);

    // Classify the sample against both bounds
    always_comb begin
        flags.below = (sample <= bound_lo);
        flags.above = (sample > bound_hi);
    end

endmodule

// File: rtl/persist_counter.sv
// Module: persist_counter
// Counts consecutive out-of-window samples and saturates at the all-ones value.
// An in-window sample zeroes it. A restart zeroes it before the current sample
// is counted. Assumes sample_valid is a one-cycle strobe per conversion.
module persist_counter #(
    parameter int PERS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic              outside,
    input  logic              restart,
    output logic [PERS_W-1:0] count_next,
    output logic [PERS_W-1:0] count_q
);

    localparam logic [PERS_W-1:0] COUNT_MAX = {PERS_W{1'b1}};

    logic [PERS_W-1:0] base;

    // Next run length, with restart applied first and saturation at the top
    always_comb begin
        base = restart ? '0 : count_q;
        if (!sample_valid) begin
            count_next = base;
        end else if (!outside) begin
            count_next = '0;
        end else if (base == COUNT_MAX) begin
            count_next = COUNT_MAX;
        end else begin
            count_next = base + 1'b1;
        end
    end

    // Hold the run length between samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_next;
        end
    end

endmodule

// File: rtl/irq_latch.sv
// Module: irq_latch
// Sticky interrupt flag with an active-low, mode-gated pin.
// A set takes priority over a clear in the same cycle. Assumes set is already
// qualified by the enable.
module irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    input  logic enable,
    output logic irq_n
);

    logic pending_q;

    // Record a fired interrupt until it is cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (set) begin
            pending_q <= 1'b1;
        end else if (clear) begin
            pending_q <= 1'b0;
        end
    end

    // Drive the pin low only while a pending interrupt is enabled
    always_comb begin
        irq_n = ~(pending_q & enable);
    end

endmodule

// File: rtl/lux_persist_irq.sv
// Module: lux_persist_irq (top)
// Compares each channel 0 result against a window and counts consecutive
// out-of-window results. Latches an active-low interrupt when the run meets the
// persistence setting, or on every result when the persistence is zero.
// Assumes the bound, persistence and mode inputs are held stable by a register
// bank, and that irq_clear is a one-cycle strobe.
module lux_persist_irq
    import lux_irq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PERS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] bound_lo,
    input  logic [DATA_W-1:0] bound_hi,
    input  logic [PERS_W-1:0] persist_sel,
    input  logic [1:0]        irq_mode,
    input  logic              irq_clear,
    output logic              irq_n
);

    window_flags_t     flags;
    logic              outside;
    logic              enabled;
    logic              fire;
    logic [PERS_W-1:0] run_next;
    logic [PERS_W-1:0] run_count;

    window_cmp #(.DATA_W(DATA_W)) i_cmp (
        .sample   (sample),
        .bound_lo (bound_lo),
        .bound_hi (bound_hi),
        .flags    (flags)
    );

    persist_counter #(.PERS_W(PERS_W)) i_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .outside      (outside),
        .restart      (irq_clear),
        .count_next   (run_next),
        .count_q      (run_count)
    );

    // Decide whether this result fires the interrupt
    always_comb begin
        outside = flags_outside(flags);
        enabled = (irq_mode == IRQ_MODE_LEVEL);
        if (persist_sel == '0) begin
            fire = sample_valid;
        end else begin
            fire = sample_valid && outside && (run_next >= persist_sel);
        end
    end

    irq_latch i_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (fire && enabled),
        .clear  (irq_clear),
        .enable (enabled),
        .irq_n  (irq_n)
    );

endmodule

// File: rtl/lux_persist_irq_chk.sv
// Module: lux_persist_irq_chk
// Property checker for lux_persist_irq, bound into every instance of the top.
module lux_persist_irq_chk #(
    parameter int DATA_W = 16,
    parameter int PERS_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_valid,
    input logic [DATA_W-1:0] sample,
    input logic [DATA_W-1:0] bound_lo,
    input logic [DATA_W-1:0] bound_hi,
    input logic [PERS_W-1:0] persist_sel,
    input logic [1:0]        irq_mode,
    input logic              irq_clear,
    input logic              irq_n,
    input logic [PERS_W-1:0] run_count
);

    localparam logic [PERS_W-1:0] RUN_MAX = {PERS_W{1'b1}};

    logic in_window;
    assign in_window = (sample > bound_lo) && (sample <= bound_hi);

    // R1: an in-window result at a nonzero persistence cannot raise an idle pin
    assert_in_window_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && in_window && persist_sel != '0 && irq_n && irq_mode == 2'b01)
        |=> irq_n);

    // R2: persistence zero fires on any result
    assert_every_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && persist_sel == '0 && irq_mode == 2'b01)
        |=> (!irq_n || irq_mode != 2'b01));

    // R4: an in-window result zeroes the run
    assert_run_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && in_window) |=> (run_count == '0));

    // R5: the run holds at its ceiling
    assert_run_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !in_window && !irq_clear && run_count == RUN_MAX)
        |=> (run_count == RUN_MAX));

    // R6: a lone clear releases the pin and zeroes the run
    assert_clear_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !sample_valid) |=> (irq_n && run_count == '0));

    // R6: an asserted pin is sticky without a clear
    assert_pin_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !irq_clear) |=> (!irq_n || irq_mode != 2'b01));

    // R8: a disabled mode keeps the pin high
    assert_disabled_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode != 2'b01) |-> irq_n);

endmodule

bind lux_persist_irq lux_persist_irq_chk #(.DATA_W(DATA_W), .PERS_W(PERS_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample       (sample),
    .bound_lo     (bound_lo),
    .bound_hi     (bound_hi),
    .persist_sel  (persist_sel),
    .irq_mode     (irq_mode),
    .irq_clear    (irq_clear),
    .irq_n        (irq_n),
    .run_count    (run_count)
);

// File: tb/test_lux_persist_irq.sv
// Directed bench for lux_persist_irq: one task per scenario.
module test_lux_persist_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] sample = '0;
    logic [15:0] bound_lo = 16'd100;
    logic [15:0] bound_hi = 16'd200;
    logic [3:0]  persist_sel = '0;
    logic [1:0]  irq_mode = 2'b01;
    logic        irq_clear = 1'b0;
    logic        irq_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lux_persist_irq i_lux_persist_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample       (sample),
        .bound_lo     (bound_lo),
        .bound_hi     (bound_hi),
        .persist_sel  (persist_sel),
        .irq_mode     (irq_mode),
        .irq_clear    (irq_clear),
        .irq_n        (irq_n)
    );

    task automatic check_pin(input logic exp, input string req, input string what);
        n_checks++;
        if (irq_n !== exp) begin
            n_fail++;
            $display("FAIL %s %s: irq_n=%0b expected %0b", req, what, irq_n, exp);
        end
    endtask

    // One result strobe; returns at the next falling edge, after the update
    task automatic push(input logic [15:0] v);
        @(negedge clk);
        sample_valid = 1'b1;
        sample = v;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    // Clear and a result in the same clock
    task automatic clear_with(input logic [15:0] v);
        @(negedge clk);
        irq_clear = 1'b1;
        sample_valid = 1'b1;
        sample = v;
        @(negedge clk);
        irq_clear = 1'b0;
        sample_valid = 1'b0;
    endtask

    task automatic t_reset();
        check_pin(1'b1, "R9", "pin after reset");
        persist_sel = 4'd2;
        push(16'd50);
        check_pin(1'b1, "R9", "run starts at zero after reset");
        do_clear();
    endtask

    task automatic t_window();
        persist_sel = 4'd1;
        push(16'd150);
        check_pin(1'b1, "R1", "mid-window sample");
        push(16'd100);
        check_pin(1'b0, "R1", "sample equal to low bound");
        do_clear();
        push(16'd101);
        check_pin(1'b1, "R1", "one above low bound");
        push(16'd200);
        check_pin(1'b1, "R1", "sample equal to high bound");
        push(16'd201);
        check_pin(1'b0, "R1", "one above high bound");
        do_clear();
        check_pin(1'b1, "R6", "clear releases pin");
    endtask

    task automatic t_every();
        persist_sel = 4'd0;
        push(16'd150);
        check_pin(1'b0, "R2", "in-window result at persistence zero");
        do_clear();
        check_pin(1'b1, "R6", "clear after persistence zero");
    endtask

    task automatic t_run();
        persist_sel = 4'd3;
        push(16'd50);
        push(16'd50);
        check_pin(1'b1, "R3", "two of three");
        repeat (5) @(negedge clk);
        check_pin(1'b1, "R3", "idle cycles do not count");
        push(16'd50);
        check_pin(1'b0, "R3", "third consecutive after idle");
        do_clear();
        persist_sel = 4'd15;
        for (int i = 0; i < 14; i++) push(16'd300);
        check_pin(1'b1, "R3", "fourteen of fifteen");
        push(16'd300);
        check_pin(1'b0, "R3", "fifteenth consecutive");
        do_clear();
    endtask

    task automatic t_break();
        persist_sel = 4'd3;
        push(16'd50);
        push(16'd50);
        push(16'd150);
        push(16'd50);
        push(16'd50);
        check_pin(1'b1, "R4", "run broken by in-window sample");
        push(16'd50);
        check_pin(1'b0, "R4", "fresh run of three");
        do_clear();
    endtask

    task automatic t_clear_run();
        persist_sel = 4'd2;
        push(16'd50);
        push(16'd50);
        check_pin(1'b0, "R6", "fires at two");
        do_clear();
        check_pin(1'b1, "R6", "released");
        push(16'd50);
        check_pin(1'b1, "R6", "run zeroed by clear");
        push(16'd50);
        check_pin(1'b0, "R6", "new run of two");
        do_clear();
    endtask

    task automatic t_collide();
        persist_sel = 4'd1;
        push(16'd50);
        check_pin(1'b0, "R7", "set before collision");
        clear_with(16'd50);
        check_pin(1'b0, "R7", "clear with qualifying result");
        clear_with(16'd150);
        check_pin(1'b1, "R7", "clear with in-window result");
    endtask

    task automatic t_disable();
        persist_sel = 4'd1;
        irq_mode = 2'b00;
        push(16'd50);
        check_pin(1'b1, "R8", "mode 00 holds pin high");
        irq_mode = 2'b01;
        @(negedge clk);
        check_pin(1'b1, "R8", "nothing latched while disabled");
        irq_mode = 2'b11;
        push(16'd50);
        check_pin(1'b1, "R8", "mode 11 holds pin high");
        irq_mode = 2'b01;
        push(16'd50);
        check_pin(1'b0, "R8", "enabled result fires");
        irq_mode = 2'b10;
        @(negedge clk);
        check_pin(1'b1, "R8", "mode 10 masks pending");
        irq_mode = 2'b01;
        @(negedge clk);
        check_pin(1'b0, "R8", "pending shows again");
        do_clear();
    endtask

    task automatic t_saturate();
        irq_mode = 2'b00;
        persist_sel = 4'd15;
        do_clear();
        for (int i = 0; i < 16; i++) push(16'd50);
        irq_mode = 2'b01;
        @(negedge clk);
        check_pin(1'b1, "R8", "tracking while disabled left pin high");
        push(16'd50);
        check_pin(1'b0, "R5", "seventeenth sample meets persistence 15");
        do_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_every();
        t_run();
        t_break();
        t_clear_run();
        t_collide();
        t_disable();
        t_saturate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule